// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Control Register

This block places a small direct-mapped cache between an instruction fetch port and a slower single-word memory port. A fetch that hits is answered in the same cycle from line storage. A fetch that misses, or any fetch made while the cache is off, is forwarded to memory as a one-word request. The fetch port is held not-ready until memory acknowledges, and the word is passed through in that acknowledge cycle.

Software manages the cache over a small control-register bus that carries a 12-bit selector, a write strobe and 32-bit write and read data. Selector 0x002 addresses the 32-bit control word. Selector 0x802 addresses the 32-bit cache address register. Writing control bits turns the cache on, freezes its contents, or invalidates one line or all lines. The line-invalidate bit uses the index held in the address register. Both invalidate bits are one-shot strobes.

The cache holds 64 lines of one 32-bit word. The index is fetch address bits [7:2], and each line stores the upper 24 address bits as its tag together with one valid bit.

Top module: `icache_ctl`

## Requirements
- R1: After reset the control word (selector 0x002) reads 0x0000_0000, so the cache starts disabled. The address register (selector 0x802) also reads zero after reset.
- R2: The control word implements bit 0 (enable) and bit 1 (freeze). Writes to all other bits have no lasting effect, and bits [31:2] always read zero. Any selector other than 0x002 or 0x802 reads zero.
- R3: While enable is 0, every fetch raises the memory request in its first cycle, even for an address held in a line. Such fetches never allocate a line. Clearing enable does not invalidate lines.
- R4: While enable is 1, a miss raises the memory request with the fetch address in the same cycle. Ready stays low until the acknowledge arrives. The memory word is returned in the acknowledge cycle, and the line at index addr[7:2] is filled so that the next fetch of that address hits with no memory request.
- R5: A hit requires a valid line whose stored tag equals addr[31:8]. A fetch that maps to the same index with a different tag misses and replaces the line.
- R6: While enable and freeze (bit 1) are both 1, hits are served from the cache. A miss returns the memory word but allocates and replaces nothing.
- R7: A control write with bit 2 set invalidates only the line indexed by address-register bits [7:2]. Other lines keep hitting.
- R8: A control write with bit 3 set invalidates every line, and the next cycle's lookup sees them all invalid. When bits 2 and 3 are both set, the invalidate-all takes effect. Bits 2 and 3 read back as zero.
- R9: The address register stores and reads back all 32 written bits.
- R10: If a line is invalidated while a refill for that line is outstanding, the refill still returns its word to the fetch port but does not mark the line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, held until ready |
| fetch_addr_i | input | 32 | Fetch byte address, word aligned |
| fetch_rdy_o | output | 1 | Fetch data valid this cycle |
| fetch_data_o | output | 32 | Fetched instruction word |
| mem_req_o | output | 1 | Memory one-word request |
| mem_addr_o | output | 32 | Memory request address |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_data_i | input | 32 | Memory read data |
| creg_sel_i | input | 12 | Control-register selector |
| creg_we_i | input | 1 | Control-register write strobe |
| creg_wdata_i | input | 32 | Control-register write data |
| creg_rdata_o | output | 32 | Control-register read data (combinational) |

## Verification
A hit sets ready and data in the request cycle. A miss sets the memory request in the request cycle and delivers ready and data in the cycle that carries the acknowledge. A control write changes state at the clock edge that ends the write cycle, and reads are combinational. The bench therefore drives inputs on the falling edge and samples 1 ns later. It judges a hit by ready high with no memory request in the first sampled cycle, and it scans forward one cycle at a time until ready, so latency is never assumed. The bench memory acknowledges the third edge after a request. This leaves room to issue an invalidating write in the middle of an outstanding refill and observe the outcome on the following fetch.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam logic [11:0] SEL_CTRL = 12'h002;
  localparam logic [11:0] SEL_ADDR = 12'h802;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_FRZ  = 1;
  localparam int unsigned BIT_CLR1 = 2;
  localparam int unsigned BIT_CLRA = 3;
endpackage

// File: rtl/cache_ctrl_regs.sv
module cache_ctrl_regs
  import icache_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [11:0]      sel_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             en_o,
  output logic             frz_o,
  output logic             inv_one_o,
  output logic             inv_all_o,
  output logic [IDX_W-1:0] inv_idx_o
);
  logic        en_q, frz_q;
  logic [31:0] caar_q;
  logic        wr_ctrl, wr_addr;

  assign wr_ctrl = we_i && (sel_i == SEL_CTRL);
  assign wr_addr = we_i && (sel_i == SEL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      frz_q  <= 1'b0;
      caar_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[BIT_EN];
        frz_q <= wdata_i[BIT_FRZ];
      end
      if (wr_addr) caar_q <= wdata_i;
    end
  end

  // clear-all wins over clear-entry
  assign inv_all_o = wr_ctrl && wdata_i[BIT_CLRA];
  assign inv_one_o = wr_ctrl && wdata_i[BIT_CLR1] && !wdata_i[BIT_CLRA];
  assign inv_idx_o = caar_q[IDX_W+1:2];
  assign en_o      = en_q;
  assign frz_o     = frz_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL: begin
        rdata_o[BIT_EN]  = en_q;
        rdata_o[BIT_FRZ] = frz_q;
      end
      SEL_ADDR: rdata_o = caar_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cache_lines.sv
module cache_lines #(
  parameter int unsigned LINES  = 64,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned TAG_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inv_all_i,
  input  logic              inv_one_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  output logic [LINES-1:0]  vld_o
);
  logic [TAG_W-1:0]  tag_w  [LINES];
  logic [DATA_W-1:0] data_w [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              vld_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;
    logic              sel_wr;

    assign sel_wr = wr_en_i && (idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    vld_r <= 1'b0;
      else if (inv_all_i)                             vld_r <= 1'b0;
      else if (inv_one_i && inv_idx_i == IDX_W'(i))   vld_r <= 1'b0;
      else if (sel_wr)                                vld_r <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel_wr) begin
        tag_r  <= wr_tag_i;
        data_r <= wr_data_i;
      end
    end

    assign vld_o[i]  = vld_r;
    assign tag_w[i]  = tag_r;
    assign data_w[i] = data_r;
  end

  assign rd_vld_o  = vld_o[idx_i];
  assign rd_tag_o  = tag_w[idx_i];
  assign rd_data_o = data_w[idx_i];
endmodule

// File: rtl/cache_refill.sv
module cache_refill #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_req_i,
  input  logic             hit_i,
  input  logic             mem_ack_i,
  input  logic             en_i,
  input  logic             frz_i,
  input  logic             inv_all_i,
  input  logic             inv_one_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             mem_req_o,
  output logic             fill_o
);
  logic kill_q, inv_hits;

  assign mem_req_o = fetch_req_i && !hit_i;
  assign inv_hits  = inv_all_i || (inv_one_i && inv_idx_i == idx_i);

  // remember an invalidation of the target line while the refill waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     kill_q <= 1'b0;
    else if (mem_req_o && !mem_ack_i) kill_q <= kill_q || inv_hits;
    else                             kill_q <= 1'b0;
  end

  assign fill_o = mem_req_o && mem_ack_i && en_i && !frz_i && !kill_q && !inv_hits;
endmodule

// File: rtl/icache_ctl.sv
module icache_ctl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_rdy_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [11:0]       creg_sel_i,
  input  logic              creg_we_i,
  input  logic [31:0]       creg_wdata_i,
  output logic [31:0]       creg_rdata_o
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - 2;

  logic              cache_en, cache_frz, inv_one, inv_all, hit, fill, rd_vld;
  logic [IDX_W-1:0]  inv_idx, idx;
  logic [TAG_W-1:0]  tag, rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic [LINES-1:0]  line_vld;
  logic              unused_lsb;

  assign idx        = fetch_addr_i[IDX_W+1:2];
  assign tag        = fetch_addr_i[ADDR_W-1:IDX_W+2];
  assign unused_lsb = ^fetch_addr_i[1:0];

  cache_ctrl_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(creg_sel_i), .we_i(creg_we_i), .wdata_i(creg_wdata_i), .rdata_o(creg_rdata_o),
    .en_o(cache_en), .frz_o(cache_frz),
    .inv_one_o(inv_one), .inv_all_o(inv_all), .inv_idx_o(inv_idx)
  );

  cache_lines #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i, .rst_ni,
    .idx_i(idx), .rd_tag_o(rd_tag), .rd_data_o(rd_data), .rd_vld_o(rd_vld),
    .wr_en_i(fill), .wr_tag_i(tag), .wr_data_i(mem_data_i),
    .inv_all_i(inv_all), .inv_one_i(inv_one), .inv_idx_i(inv_idx),
    .vld_o(line_vld)
  );

  assign hit = cache_en && rd_vld && (rd_tag == tag);

  cache_refill #(.IDX_W(IDX_W)) u_refill (
    .clk_i, .rst_ni,
    .fetch_req_i, .hit_i(hit), .mem_ack_i,
    .en_i(cache_en), .frz_i(cache_frz),
    .inv_all_i(inv_all), .inv_one_i(inv_one), .inv_idx_i(inv_idx),
    .idx_i(idx), .mem_req_o, .fill_o(fill)
  );

  assign mem_addr_o   = fetch_addr_i;
  assign fetch_rdy_o  = fetch_req_i && (hit || mem_ack_i);
  assign fetch_data_o = hit ? rd_data : mem_data_i;
endmodule

// File: rtl/icache_ctl_chk.sv
module icache_ctl_chk #(
  parameter int unsigned LINES = 64,
  parameter int unsigned IDX_W = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_req_i,
  input logic             fetch_rdy_o,
  input logic             mem_req_o,
  input logic             mem_ack_i,
  input logic [11:0]      creg_sel_i,
  input logic [31:0]      creg_rdata_o,
  input logic             cache_en,
  input logic             cache_frz,
  input logic             inv_one,
  input logic             inv_all,
  input logic [IDX_W-1:0] inv_idx,
  input logic [LINES-1:0] line_vld
);
  // R2
  a_r2_ctrl_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (creg_sel_i == 12'h002) |-> (creg_rdata_o[31:2] == '0));
  // R3
  a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !cache_en) |-> mem_req_o);
  // R4
  a_r4_wait_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |-> !fetch_rdy_o);
  // R4
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i |-> (!mem_req_o && !fetch_rdy_o));
  // R6
  a_r6_freeze_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_en && cache_frz) |=> ((line_vld & ~$past(line_vld)) == '0));
  // R7
  a_r7_clear_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_one |=> !line_vld[$past(inv_idx)]);
  // R8
  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all |=> (line_vld == '0));
endmodule

bind icache_ctl icache_ctl_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/icache_ctl_test.sv
module icache_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_rdy_o;
  logic [31:0] fetch_data_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic [11:0] creg_sel_i = '0;
  logic        creg_we_i = 1'b0;
  logic [31:0] creg_wdata_i = '0;
  logic [31:0] creg_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  int lat   = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  icache_ctl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i, .fetch_addr_i, .fetch_rdy_o, .fetch_data_o,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_data_i,
    .creg_sel_i, .creg_we_i, .creg_wdata_i, .creg_rdata_o
  );

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
  endfunction

  // memory: acknowledges on the third edge of a request
  always @(posedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
      lat       <= 0;
    end else if (mem_req_o) begin
      if (lat == 2) begin
        mem_ack_i  <= 1'b1;
        mem_data_i <= mword(mem_addr_o);
        lat        <= 0;
      end else lat <= lat + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, output logic hit, output logic [31:0] d);
    @(negedge clk);
    fetch_req_i  = 1'b1;
    fetch_addr_i = a;
    #1;
    hit = fetch_rdy_o && !mem_req_o;
    while (!fetch_rdy_o) begin
      @(negedge clk);
      #1;
    end
    d = fetch_data_o;
    @(posedge clk);
    #1;
    fetch_req_i = 1'b0;
  endtask

  task automatic cwrite(input logic [11:0] s, input logic [31:0] v);
    @(negedge clk);
    creg_sel_i   = s;
    creg_wdata_i = v;
    creg_we_i    = 1'b1;
    @(negedge clk);
    creg_we_i    = 1'b0;
  endtask

  task automatic cread(input logic [11:0] s, output logic [31:0] v);
    @(negedge clk);
    creg_sel_i = s;
    #1;
    v = creg_rdata_o;
  endtask

  task automatic fchk(input string req, input logic [31:0] a, input logic exp_hit);
    logic h;
    logic [31:0] d;
    fetch(a, h, d);
    chk({req, " hit"}, 32'(h), 32'(exp_hit));
    chk({req, " data"}, d, mword(a));
  endtask

  // {expected hit, address}, cache enabled and empty at start
  localparam logic [32:0] VEC [11] = '{
    {1'b0, 32'h0000_0100}, {1'b1, 32'h0000_0100},
    {1'b0, 32'h0000_0104}, {1'b1, 32'h0000_0104},
    {1'b0, 32'h0000_1100}, {1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_0104}, {1'b0, 32'h0000_01FC},
    {1'b1, 32'h0000_01FC}, {1'b0, 32'hFFFF_FF00},
    {1'b1, 32'hFFFF_FF00}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R4 act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic h;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cread(12'h002, v); chk("R1 ctrl after reset", v, 32'h0);
    cread(12'h802, v); chk("R1 addr reg after reset", v, 32'h0);

    // R3 disabled: repeated fetch always goes to memory
    fchk("R3 disabled first", 32'h0000_0100, 1'b0);
    fchk("R3 disabled repeat", 32'h0000_0100, 1'b0);

    // R2 unimplemented bits
    cwrite(12'h002, 32'hFFFF_FFF0);
    cread(12'h002, v); chk("R2 high bits ignored", v, 32'h0);
    cwrite(12'h002, 32'h1);
    cread(12'h002, v); chk("R2 enable readback", v, 32'h1);
    cread(12'h001, v); chk("R2 unmapped selector", v, 32'h0);

    // R3 nothing was allocated while disabled
    fchk("R3 no alloc while off", 32'h0000_0100, 1'b0);

    // R8 clear-all, then vector table
    cwrite(12'h002, 32'h9);
    cread(12'h002, v); chk("R8 clear bits read zero", v, 32'h1);
    for (int i = 0; i < 11; i++)
      fchk($sformatf("R4/R5 vec%0d", i), VEC[i][31:0], VEC[i][32]);

    // R9 / R7 clear single entry (index 1)
    cwrite(12'h802, 32'hDEAD_0104);
    cread(12'h802, v); chk("R9 addr reg readback", v, 32'hDEAD_0104);
    cwrite(12'h002, 32'h5);
    fchk("R7 cleared line misses", 32'h0000_0104, 1'b0);
    fchk("R7 other line hits", 32'h0000_01FC, 1'b1);

    // R6 freeze
    cwrite(12'h002, 32'h3);
    cread(12'h002, v); chk("R6 freeze readback", v, 32'h3);
    fchk("R6 frozen hit", 32'h0000_01FC, 1'b1);
    fchk("R6 frozen miss", 32'h0000_2104, 1'b0);
    fchk("R6 frozen miss again", 32'h0000_2104, 1'b0);
    fchk("R6 old line kept", 32'h0000_0104, 1'b1);
    cwrite(12'h002, 32'h1);

    // R8 precedence: both clear bits, addr reg index 1
    cwrite(12'h002, 32'hD);
    fchk("R8 all cleared idx63", 32'h0000_01FC, 1'b0);
    fchk("R8 all cleared idx0", 32'hFFFF_FF00, 1'b0);

    // R10 invalidate during refill
    cwrite(12'h802, 32'h0000_0208);
    fork
      fetch(32'h0000_0208, h, d);
      begin
        @(negedge clk);
        cwrite(12'h002, 32'h5);
      end
    join
    chk("R10 killed refill data", d, mword(32'h0000_0208));
    fchk("R10 line not filled", 32'h0000_0208, 1'b0);
    fchk("R10 refetch fills", 32'h0000_0208, 1'b1);

    // R3 disable bypasses a valid line without clearing it
    cwrite(12'h002, 32'h0);
    fchk("R3 off bypasses line", 32'h0000_01FC, 1'b0);
    cwrite(12'h002, 32'h1);
    fchk("R3 line survives disable", 32'h0000_01FC, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule